// File: doc/BRIEF.md
# Mesochronous Rotating-Bank Input Synchronizer

This block carries flits from a sender clock domain into a receiver clock domain that runs at the same frequency but at an unknown, fixed phase. It also stands in for the switch input buffer. The sender's forwarded clock captures each accepted flit into one of three storage banks, and the banks are used in turn. On the receiver side, a pointer clocked by the receiver clock picks one bank through a multiplexer and loads it into an output register that feeds the switch.

A flag per bank, toggled by the sender side on each write, travels next to the data. This parallel control path lets the receiver see which banks hold unread flits. A matching flag, toggled by the receiver on each read, returns to the sender through single-bit synchronizers. That return path forms the backward go signal `tx_ready`. The switch arbiter applies stall directly to this structure, so a stalled flit waits in the banks and in the output register, not in any extra buffer. The same reset state is correct for every phase relationship, so the block needs no phase detector.

Top module: `meso_sync_ibuf`

## Requirements
- R1: Every flit accepted at the sender side appears exactly once at `out_data`, in acceptance order. A flit is accepted on a rising `clk_tx` edge where `tx_valid` and `tx_ready` are both high. A flit leaves on a rising `clk_rx` edge where `out_valid` is high and `rx_stall` is low.
- R2: The banks are written in strict rotation. While `rx_stall` is held high from an empty state, the sender side accepts exactly NBANK flits and then holds `tx_ready` low. While `tx_ready` is low, the write pointer does not move.
- R3: While `rx_stall` is high, the receiver pointer does not advance, and `out_valid` and `out_data` keep their values across the clock edge.
- R4: `out_valid` is low whenever no accepted flit remains undelivered. An empty output register stays empty under stall.
- R5: While `rst_n` is low, `out_valid` and `tx_ready` are low. Within eight receiver cycles after `rst_n` rises, `tx_ready` is high.
- R6: R1 holds for any phase offset of `clk_tx` relative to `clk_rx`, including while the phase shifts during traffic, with a single fixed reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tx | input | 1 | Forwarded sender clock, strobe for data and valid |
| tx_valid | input | 1 | Sender offers a flit |
| tx_data | input | DW | Flit payload from sender |
| tx_ready | output | 1 | Backward go toward sender, in the `clk_tx` domain |
| clk_rx | input | 1 | Receiver (switch) clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released per domain through synchronizers |
| rx_stall | input | 1 | Stall from the switch arbiter, high holds the output flit |
| out_valid | output | 1 | Output register holds a flit |
| out_data | output | DW | Flit to the switch logic |

## Verification
The hardest state to reach is all banks full while the receiver is stalled, combined with a phase offset the bench has only just moved to. The sender clock generator stretches one low phase by an eighth of a period at each step, so the phase walks around the whole period while flits are in flight. In a dedicated window, stall is held high with the sender always offering data. This fills every bank and lets the bench count how many flits are accepted before `tx_ready` drops. Random stall and random sender gaps between steps exercise the hold and pointer-freeze paths at every phase.

// File: rtl/meso_sync_pkg.sv
package meso_sync_pkg;

  // Next position on a ring of n banks.
  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/meso_bit_sync.sv
module meso_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/meso_front.sv
module meso_front
  import meso_sync_pkg::*;
#(
  parameter int DW          = 32,
  parameter int NBANK       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_tx,
  input  logic                        rst_tx_n,
  input  logic                        tx_valid,
  input  logic [DW-1:0]               tx_data,
  input  logic [NBANK-1:0]            rd_flag_async,
  output logic                        tx_ready,
  output logic [NBANK-1:0]            wr_flag,
  output logic [NBANK-1:0][DW-1:0]    bank_data
);

  localparam int PW = $clog2(NBANK);

  logic [PW-1:0]              wr_q, wr_d;
  logic [NBANK-1:0]           wflag_q, wflag_d;
  logic [NBANK-1:0]           rflag_s;
  logic [NBANK-1:0]           bank_we;
  logic [NBANK-1:0][DW-1:0]   bank_q;
  logic                       live_q;
  logic                       busy, fire;

  // One single-bit synchronizer per returning read flag.
  for (genvar b = 0; b < NBANK; b++) begin : g_rsync
    meso_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_tx),
      .rst_n (rst_tx_n),
      .d     (rd_flag_async[b]),
      .q     (rflag_s[b])
    );
  end

  always_comb begin
    busy     = wflag_q[wr_q] ^ rflag_s[wr_q];
    tx_ready = live_q & ~busy;
    fire     = tx_valid & tx_ready;
    wr_d     = fire ? PW'(ring_next(32'(wr_q), NBANK)) : wr_q;
    wflag_d  = wflag_q;
    bank_we  = '0;
    if (fire) begin
      wflag_d[wr_q] = ~wflag_q[wr_q];
      bank_we[wr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_tx or negedge rst_tx_n) begin
    if (!rst_tx_n) begin
      live_q  <= 1'b0;
      wr_q    <= '0;
      wflag_q <= '0;
    end else begin
      live_q  <= 1'b1;
      wr_q    <= wr_d;
      wflag_q <= wflag_d;
    end
  end

  // Payload banks: no reset, per-bank clock enable.
  always_ff @(posedge clk_tx) begin
    for (int b = 0; b < NBANK; b++) begin
      if (bank_we[b]) bank_q[b] <= tx_data;
    end
  end

  assign wr_flag   = wflag_q;
  assign bank_data = bank_q;

  assert_wr_still_R2: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
    !tx_ready |=> $stable(wr_q));

  always_comb begin
    if (!rst_tx_n) begin
      assert_ready_low_in_reset_R5: assert (!tx_ready);
    end
  end

endmodule

// File: rtl/meso_back.sv
module meso_back
  import meso_sync_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NBANK = 3
) (
  input  logic                        clk_rx,
  input  logic                        rst_rx_n,
  input  logic                        rx_stall,
  input  logic [NBANK-1:0]            wr_flag_async,
  input  logic [NBANK-1:0][DW-1:0]    bank_data,
  output logic [NBANK-1:0]            rd_flag,
  output logic                        out_valid,
  output logic [DW-1:0]               out_data
);

  localparam int PW = $clog2(NBANK);

  logic [PW-1:0]    rd_q, rd_d;
  logic [NBANK-1:0] rflag_q, rflag_d;
  logic [NBANK-1:0] seen_q, seen_d;
  logic             ov_q, ov_d;
  logic [DW-1:0]    od_q;
  logic             take;

  always_comb begin
    seen_d  = wr_flag_async ^ rflag_q;
    take    = ~rx_stall & seen_q[rd_q];
    ov_d    = rx_stall ? ov_q : take;
    rd_d    = take ? PW'(ring_next(32'(rd_q), NBANK)) : rd_q;
    rflag_d = rflag_q;
    if (take) rflag_d[rd_q] = ~rflag_q[rd_q];
  end

  always_ff @(posedge clk_rx or negedge rst_rx_n) begin
    if (!rst_rx_n) begin
      rd_q    <= '0;
      rflag_q <= '0;
      seen_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      rflag_q <= rflag_d;
      seen_q  <= seen_d;
      ov_q    <= ov_d;
    end
  end

  // Output payload: no reset, loads only on a read.
  always_ff @(posedge clk_rx) begin
    if (take) od_q <= bank_data[rd_q];
  end

  assign rd_flag   = rflag_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  assert_hold_on_stall_R3: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (rx_stall && out_valid) |=> (out_valid && $stable(out_data)));

  assert_rd_frozen_R3: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    rx_stall |=> $stable(rd_q));

  assert_rd_in_ring_R1: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    32'(rd_q) < NBANK);

endmodule

// File: rtl/meso_sync_ibuf.sv
module meso_sync_ibuf #(
  parameter int DW          = 32,
  parameter int NBANK       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_tx,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  input  logic          clk_rx,
  input  logic          rst_n,
  input  logic          rx_stall,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic                     rst_tx_n, rst_rx_n;
  logic [NBANK-1:0]         wr_flag, rd_flag;
  logic [NBANK-1:0][DW-1:0] bank_data;

  meso_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_tx (
    .clk (clk_tx), .rst_n (rst_n), .d (1'b1), .q (rst_tx_n)
  );

  meso_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_rx (
    .clk (clk_rx), .rst_n (rst_n), .d (1'b1), .q (rst_rx_n)
  );

  meso_front #(.DW(DW), .NBANK(NBANK), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_tx        (clk_tx),
    .rst_tx_n      (rst_tx_n),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .rd_flag_async (rd_flag),
    .tx_ready      (tx_ready),
    .wr_flag       (wr_flag),
    .bank_data     (bank_data)
  );

  meso_back #(.DW(DW), .NBANK(NBANK)) u_back (
    .clk_rx        (clk_rx),
    .rst_rx_n      (rst_rx_n),
    .rx_stall      (rx_stall),
    .wr_flag_async (wr_flag),
    .bank_data     (bank_data),
    .rd_flag       (rd_flag),
    .out_valid     (out_valid),
    .out_data      (out_data)
  );

endmodule

// File: tb/tb_meso_sync_ibuf.sv
`timescale 1ns/1ps
module tb_meso_sync_ibuf;

  localparam int DW    = 32;
  localparam int NBANK = 3;

  logic          clk_tx, clk_rx, rst_n;
  logic          tx_valid, tx_ready, rx_stall, out_valid;
  logic [DW-1:0] tx_data, out_data;

  meso_sync_ibuf #(.DW(DW), .NBANK(NBANK)) dut (
    .clk_tx (clk_tx), .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
    .clk_rx (clk_rx), .rst_n (rst_n), .rx_stall (rx_stall),
    .out_valid (out_valid), .out_data (out_data)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int unsigned tx_pct = 0;
  int unsigned st_pct = 0;
  int          acc_cnt = 0;
  bit          run = 0;
  bit          hold_prev = 0;
  real         tx_shift = 0.0;
  logic [DW-1:0] seq = '0;
  logic [DW-1:0] held_data;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // 200 MHz receiver clock
  initial begin
    clk_rx = 0;
    forever #2.5 clk_rx = ~clk_rx;
  end

  // Sender clock, same period; each requested shift stretches one low phase.
  initial begin
    clk_tx = 0;
    #1.3;
    forever begin
      clk_tx = 1; #2.5;
      clk_tx = 0; #2.5;
      if (tx_shift > 0.0) begin
        #(tx_shift);
        tx_shift = 0.0;
      end
    end
  end

  // Sender model: decide at mid-cycle, record what the next edge accepts.
  initial begin
    tx_valid = 0;
    tx_data  = '0;
  end
  always @(negedge clk_tx) begin
    tx_valid = ($urandom_range(99) < tx_pct);
    tx_data  = seq;
    if (tx_valid && tx_ready) begin
      exp_q.push_back(seq);
      seq = seq + 1;
      acc_cnt++;
    end
  end

  // Receiver model and comparison every receiver cycle.
  initial rx_stall = 0;
  always @(negedge clk_rx) begin
    if (rst_n && run) begin
      if (hold_prev) begin
        chk(out_valid === 1'b1, "R3 valid held under stall", out_valid, 1);
        chk(out_data === held_data, "R3 data held under stall", out_data, held_data);
      end
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R4 output with nothing pending", out_data, -1);
        else chk(out_data === exp_q[0], "R1/R6 flit order", out_data, exp_q[0]);
      end else if (exp_q.size() == 0) begin
        chk(out_valid === 1'b0, "R4 idle output", out_valid, 0);
      end
      rx_stall = ($urandom_range(99) < st_pct);
      if (out_valid && !rx_stall && exp_q.size() != 0) void'(exp_q.pop_front());
      hold_prev = out_valid && rx_stall;
      held_data = out_data;
    end else begin
      rx_stall  = 0;
      hold_prev = 0;
    end
  end

  // Watchdog
  always @(posedge clk_rx) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk_rx);
    chk(out_valid === 1'b0, "R5 out_valid in reset", out_valid, 0);
    chk(tx_ready === 1'b0, "R5 tx_ready in reset", tx_ready, 0);
    rst_n = 1;
    repeat (8) @(negedge clk_rx);
    chk(tx_ready === 1'b1, "R5 tx_ready after release", tx_ready, 1);
    chk(out_valid === 1'b0, "R4 empty after release", out_valid, 0);
    run = 1;

    // Phase sweep: eight steps of one eighth period each.
    for (int ph = 0; ph < 8; ph++) begin
      if (ph > 0) tx_shift = 0.625;
      tx_pct = (ph % 2 == 0) ? 100 : 60;
      st_pct = (ph < 2) ? 0 : 30;
      repeat (400) @(negedge clk_rx);
      tx_pct = 0;
      st_pct = 0;
      repeat (40) @(negedge clk_rx);
      chk(exp_q.size() == 0, "R6 all flits delivered at this phase", exp_q.size(), 0);
    end

    // Back-pressure window: stall held, sender always offering.
    st_pct = 100;
    repeat (3) @(negedge clk_rx);
    acc_cnt = 0;
    tx_pct = 100;
    repeat (40) @(negedge clk_rx);
    chk(tx_ready === 1'b0, "R2 go low with banks full", tx_ready, 0);
    chk(out_valid === 1'b0, "R4 empty output stays empty under stall", out_valid, 0);
    tx_pct = 0;
    repeat (3) @(negedge clk_rx);
    chk(acc_cnt == NBANK, "R2 accepted count under stall", acc_cnt, NBANK);
    st_pct = 0;
    repeat (40) @(negedge clk_rx);
    chk(exp_q.size() == 0, "R1 no loss after back-pressure", exp_q.size(), 0);
    chk(out_valid === 1'b0, "R4 idle at end", out_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule